// File: doc/BRIEF.md
# Quasi-Random and User-Code Test Pattern Source

This block drives the transmit side of a line test unit with a serial test bit stream. It runs in one of two sources. The first is a quasi-random signal taken from a 20-stage feedback shift register, with a suppression rule that caps runs of zeros on the line. The second is a user-programmed word of 1 to 32 bits that repeats without a break. A bit-enable strobe paces the stream, so the same block serves any line rate that is derived from the core clock.

The caller selects the source and supplies the user word and its length, then raises the run control. Those settings are captured at the start and held until the next stop. Dropping the run control ends the stream, and the line then sits at 0. This is the same action as an explicit stop of any test in progress. A one-cycle marker shows where each pattern period begins, so a receiver or a counter can align to it.

Top module: `qrs_pattern_gen`

## Requirements
- R1: While reset is high, and after it until the first start, `bit_out` and `restart` are 0.
- R2: When `run` is high while the block is stopped, the block starts on that clock edge. It captures `pat_sel`, `user_code` and `user_len` and loads the shift register with all ones, so the first bit sent is the bit of the all-ones state.
- R3: With `pat_sel` = 0 (quasi-random), stage 1 is loaded with stage 17 XOR stage 20 on each advance, and the other stages shift up by one. The raw line bit is stage 20, not inverted, and the raw sequence repeats every 2^20 − 1 bits.
- R4: In quasi-random mode, `bit_out` is forced to 1 in any bit whose next 14 raw bits (stages 19 down to 6) are all zero. The forcing changes only the output and never the register feedback.
- R5: The pattern state advances only on clock edges where `bit_en` is 1. Otherwise `bit_out` holds its value.
- R6: With `pat_sel` = 1 (user code), `bit_out` sends bits L−1 down to 0 of `user_code` and then wraps, where L = `user_len`. An L of 0 or an L above 32 acts as 32.
- R7: `restart` is 1 only in a cycle where `bit_en` is 1 and the current bit is the first bit of a period. That is the all-ones register state in quasi-random mode, or bit L−1 in user-code mode.
- R8: If `run` is 0 at a clock edge, the block stops. From the next cycle `bit_out` and `restart` are 0, and a later start reseeds the pattern.
- R9: Changes to `pat_sel`, `user_code` or `user_len` while running have no effect on the stream until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate strobe; the pattern advances on edges where it is high |
| pat_sel | input | 1 | Source choice: 0 quasi-random, 1 user code |
| user_code | input | 32 | User pattern word |
| user_len | input | 6 | User pattern length in bits (0 or above 32 means 32) |
| run | input | 1 | Start when high while stopped; stop when low |
| bit_out | output | 1 | Serial test bit |
| restart | output | 1 | Marks the first bit of each pattern period on a strobe cycle |

## Verification
The hardest condition to reach from the ports is the return to the seed, which happens only after 1,048,575 strobed bits. Zero runs long enough to force a 1 are also sparse in the 20-stage sequence. For this reason a second instance with a 7-stage register, a 4-bit suppression window and a 127-bit period runs on the same stimulus. It goes through several full periods and many forced ones, while the default instance is compared bit by bit over a long stretch. The user-code path is swept over every length from 0 to 40 with an irregular strobe. That sweep includes a mid-stream change of every setting and stop/start reseeding.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    // Source of the serial stream, chosen at start time.
    typedef enum logic {
        SRC_QRS  = 1'b0,
        SRC_USER = 1'b1
    } src_e;

endpackage

// File: rtl/qrs_lfsr_step.sv
// Next-state and line-bit logic of the quasi-random register.
// Bit k-1 of the vector holds stage k; stage 1 takes the feedback.
module qrs_lfsr_step #(
    parameter int LFSR_W = 20,
    parameter int TAP    = 17,
    parameter int ZRUN   = 14
) (
    input  logic [LFSR_W-1:0] cur,
    output logic [LFSR_W-1:0] nxt,
    output logic              line_bit,
    output logic              at_seed
);
    logic fb;
    logic quiet;

    always_comb begin
        fb       = cur[LFSR_W-1] ^ cur[TAP-1];
        nxt      = {cur[LFSR_W-2:0], fb};
        // The next ZRUN raw bits sit just below the output stage.
        quiet    = (cur[LFSR_W-2 -: ZRUN] == '0);
        line_bit = cur[LFSR_W-1] | quiet;
        at_seed  = &cur;
    end
endmodule

// File: rtl/qrs_len_norm.sv
// Turns a requested user length into the index of the first bit sent.
module qrs_len_norm #(
    parameter int CODE_W = 32,
    localparam int IDX_W = $clog2(CODE_W),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] first
);
    always_comb begin
        if (len == '0 || len > LEN_W'(CODE_W)) begin
            first = IDX_W'(CODE_W - 1);
        end else begin
            first = IDX_W'(len - 1'b1);
        end
    end
endmodule

// File: rtl/qrs_code_step.sv
// Bit pick and index walk of the user-code source, MSB of the period first.
module qrs_code_step #(
    parameter int CODE_W = 32,
    localparam int IDX_W = $clog2(CODE_W)
) (
    input  logic [CODE_W-1:0] code,
    input  logic [IDX_W-1:0]  first,
    input  logic [IDX_W-1:0]  idx,
    output logic              code_bit,
    output logic [IDX_W-1:0]  nxt_idx,
    output logic              at_first
);
    always_comb begin
        code_bit = code[idx];
        at_first = (idx == first);
        nxt_idx  = (idx == '0) ? first : idx - 1'b1;
    end
endmodule

// File: rtl/qrs_pattern_gen.sv
module qrs_pattern_gen
    import qrs_pkg::*;
#(
    parameter int LFSR_W = 20,
    parameter int TAP    = 17,
    parameter int ZRUN   = 14,
    parameter int CODE_W = 32,
    localparam int IDX_W = $clog2(CODE_W),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              pat_sel,
    input  logic [CODE_W-1:0] user_code,
    input  logic [LEN_W-1:0]  user_len,
    input  logic              run,
    output logic              bit_out,
    output logic              restart
);
    typedef struct packed {
        logic              running;
        src_e              src;
        logic [CODE_W-1:0] code;
        logic [IDX_W-1:0]  first;
        logic [IDX_W-1:0]  idx;
        logic [LFSR_W-1:0] lfsr;
    } state_t;

    state_t st_d, st_q;

    logic [LFSR_W-1:0] lfsr_nxt;
    logic              line_bit;
    logic              at_seed;
    logic [IDX_W-1:0]  first_in;
    logic              code_bit;
    logic [IDX_W-1:0]  idx_nxt;
    logic              at_first;

    qrs_lfsr_step #(
        .LFSR_W (LFSR_W),
        .TAP    (TAP),
        .ZRUN   (ZRUN)
    ) u_lfsr (
        .cur      (st_q.lfsr),
        .nxt      (lfsr_nxt),
        .line_bit (line_bit),
        .at_seed  (at_seed)
    );

    qrs_len_norm #(
        .CODE_W (CODE_W)
    ) u_len (
        .len   (user_len),
        .first (first_in)
    );

    qrs_code_step #(
        .CODE_W (CODE_W)
    ) u_code (
        .code     (st_q.code),
        .first    (st_q.first),
        .idx      (st_q.idx),
        .code_bit (code_bit),
        .nxt_idx  (idx_nxt),
        .at_first (at_first)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.running) begin
            if (run) begin
                st_d.running = 1'b1;
                st_d.src     = src_e'(pat_sel);
                st_d.code    = user_code;
                st_d.first   = first_in;
                st_d.idx     = first_in;
                st_d.lfsr    = '1;
            end
        end else if (!run) begin
            st_d.running = 1'b0;
        end else if (bit_en) begin
            if (st_q.src == SRC_USER) begin
                st_d.idx = idx_nxt;
            end else begin
                st_d.lfsr = lfsr_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.running <= 1'b0;
            st_q.src     <= SRC_QRS;
            st_q.code    <= '0;
            st_q.first   <= '0;
            st_q.idx     <= '0;
            st_q.lfsr    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.running &
                     ((st_q.src == SRC_USER) ? code_bit : line_bit);
    assign restart = st_q.running & bit_en &
                     ((st_q.src == SRC_USER) ? at_first : at_seed);

endmodule

// File: rtl/qrs_pattern_gen_chk.sv
module qrs_pattern_gen_chk
    import qrs_pkg::*;
#(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         bit_en,
    input logic         bit_out,
    input logic         restart,
    input logic         running,
    input src_e         src,
    input logic [W-1:0] lfsr
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bit_out && !restart));

    assert_no_lockup_R2: assert property (@(posedge clk) disable iff (rst)
        running |-> (lfsr != '0));

    assert_plain_output_R3: assert property (@(posedge clk) disable iff (rst)
        (running && src == SRC_QRS && lfsr[W-1]) |-> bit_out);

    assert_hold_on_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (running && run && !bit_en) |=> ($stable(lfsr) && $stable(bit_out)));

    assert_marker_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        restart |-> (bit_en && running));

    assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!bit_out && !restart));

    assert_source_held_R9: assert property (@(posedge clk) disable iff (rst)
        (running && run) |=> $stable(src));
endmodule

bind qrs_pattern_gen qrs_pattern_gen_chk #(.W(LFSR_W)) chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .bit_en  (bit_en),
    .bit_out (bit_out),
    .restart (restart),
    .running (st_q.running),
    .src     (st_q.src),
    .lfsr    (st_q.lfsr)
);

// File: tb/qrs_pattern_gen_test.sv
module qrs_pattern_gen_test;
    localparam int CLK_NS = 10;
    localparam int WA = 20, TA = 17, ZA = 14;
    localparam int WB = 7,  TB = 6,  ZB = 4;
    localparam int PA = (1 << WA) - 1;
    localparam int PB = (1 << WB) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        pat_sel = 1'b0;
    logic [31:0] user_code = '0;
    logic [5:0]  user_len = '0;
    logic        run = 1'b0;
    logic        out_a, mark_a, out_b, mark_b;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    qrs_pattern_gen uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .pat_sel(pat_sel),
        .user_code(user_code), .user_len(user_len), .run(run),
        .bit_out(out_a), .restart(mark_a)
    );

    qrs_pattern_gen #(.LFSR_W(WB), .TAP(TB), .ZRUN(ZB)) uut_small (
        .clk(clk), .rst(rst), .bit_en(bit_en), .pat_sel(pat_sel),
        .user_code(user_code), .user_len(user_len), .run(run),
        .bit_out(out_b), .restart(mark_b)
    );

    // Reference state built from the stated stage rules.
    logic [WA-1:0] ma;
    logic [WB-1:0] mb;
    bit qa[$];
    bit qb[$];
    int pa, pb, since_start, forced_b, marks_b;
    bit user_mode;
    logic [31:0] ucode;
    int ulen, upos;
    string tag_over = "";

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_a();
        bit r;
        r  = ma[WA-1];
        ma = {ma[WA-2:0], ma[WA-1] ^ ma[TA-1]};
        qa.push_back(r);
    endtask

    task automatic push_b();
        bit r;
        r  = mb[WB-1];
        mb = {mb[WB-2:0], mb[WB-1] ^ mb[TB-1]};
        qb.push_back(r);
    endtask

    task automatic model_seed();
        ma = '1; mb = '1;
        qa.delete(); qb.delete();
        pa = 0; pb = 0; upos = 0; since_start = 0;
        repeat (ZA + 1) push_a();
        repeat (ZB + 1) push_b();
    endtask

    task automatic step(input bit en);
        bit ea, eb, za, zb, ema, emb;
        string tag;
        @(negedge clk);
        bit_en = en;
        #1;
        if (user_mode) begin
            ea  = ucode[ulen - 1 - upos];
            eb  = ea;
            ema = en && (upos == 0);
            emb = ema;
            tag = "R6";
        end else begin
            za = 1; zb = 1;
            for (int i = 1; i <= ZA; i++) if (qa[i]) za = 0;
            for (int i = 1; i <= ZB; i++) if (qb[i]) zb = 0;
            ea  = qa[0] | za;
            eb  = qb[0] | zb;
            if (zb && !qb[0]) forced_b++;
            ema = en && (pa == 0);
            emb = en && (pb == 0);
            tag = (since_start < 32) ? "R2" : "R4";
        end
        if (!en) tag = "R5";
        if (tag_over != "") tag = tag_over;
        check(out_a == ea, tag, 32'(out_a), 32'(ea));
        check(out_b == eb, tag, 32'(out_b), 32'(eb));
        check(mark_a == ema, "R7", 32'(mark_a), 32'(ema));
        check(mark_b == emb, "R7", 32'(mark_b), 32'(emb));
        if (mark_b) marks_b++;
        @(posedge clk);
        if (en) begin
            since_start++;
            if (user_mode) begin
                upos = (upos + 1) % ulen;
            end else begin
                void'(qa.pop_front()); push_a(); pa = (pa + 1) % PA;
                void'(qb.pop_front()); push_b(); pb = (pb + 1) % PB;
            end
        end
    endtask

    task automatic stop_gen();
        @(negedge clk);
        run = 1'b0;
        bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        // R8: stopped output and marker are quiet even with the strobe high
        check(out_a == 1'b0 && out_b == 1'b0, "R8", {30'd0, out_a, out_b}, 32'd0);
        check(mark_a == 1'b0 && mark_b == 1'b0, "R8", {30'd0, mark_a, mark_b}, 32'd0);
    endtask

    task automatic start_gen(input bit sel, input logic [31:0] code, input int len);
        @(negedge clk);
        pat_sel = sel;
        user_code = code;
        user_len = 6'(len);
        run = 1'b1;
        bit_en = 1'b0;
        user_mode = sel;
        ucode = code;
        ulen = (len == 0 || len > 32) ? 32 : len;
        model_seed();
        @(posedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        forced_b = 0;
        marks_b = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bit_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            // R1: quiet after reset while run stays low
            check(out_a == 1'b0 && out_b == 1'b0, "R1", {30'd0, out_a, out_b}, 32'd0);
            check(mark_a == 1'b0 && mark_b == 1'b0, "R1", {30'd0, mark_a, mark_b}, 32'd0);
            @(negedge clk);
        end

        // Quasi-random source (R3, R4): several small periods, irregular strobe.
        start_gen(1'b0, 32'h0, 0);
        for (int k = 0; k < 700; k++) step($urandom_range(3) != 0);
        // Stop, then restart from the seed (R8, R2).
        stop_gen();
        start_gen(1'b0, 32'h0, 0);
        for (int k = 0; k < 30000; k++) step(1'b1);
        check(forced_b > 0, "R4", 32'(forced_b), 32'd1);
        check(marks_b >= 2, "R3", 32'(marks_b), 32'd2);
        stop_gen();

        // User-code sweep over every length, including 0 and above 32 (R6).
        for (int len = 0; len <= 40; len++) begin
            start_gen(1'b1, 32'hA5C3_96E1 ^ (32'(len) * 32'h0101_0107), len);
            for (int k = 0; k < 2 * ulen + 6; k++) step($urandom_range(3) != 0);
            stop_gen();
        end

        // Mid-stream changes are ignored until the next start (R9).
        start_gen(1'b1, 32'h0000_0013, 5);
        for (int k = 0; k < 4; k++) step(1'b1);
        pat_sel = 1'b0;
        user_code = 32'h0000_0F0C;
        user_len = 6'd12;
        tag_over = "R9";
        for (int k = 0; k < 16; k++) step(1'b1);
        tag_over = "";
        stop_gen();
        start_gen(1'b1, 32'h0000_0F0C, 12);
        tag_over = "R9";
        for (int k = 0; k < 30; k++) step($urandom_range(1) != 0);
        tag_over = "";
        stop_gen();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule